// File: doc/BRIEF.md
# Latched Serial Status Reporter

This block keeps a 27-bit record of system status and sends it to a management controller over a slow serial link. The controller drives two wires, a snapshot request and a shift clock of about 1 MHz. Both are asynchronous to the fast local clock. A rising snapshot request copies the current record into a shift register. Each falling edge of the shift clock then moves the next bit onto the data output, so the controller can sample that bit on the following rising edge.

The record also holds the first failure. A falling edge on any monitored power-good input sets a sticky dirty flag. From that moment the record stops following the live inputs, so the controller reads the state of the system at the first failure and not whatever came after it. The flag is cleared in only two ways: a complete read made while the system reports the soft-off state, or a reset, which stands for loss of AC power.

The top bit of the serial word is the dirty flag. Below it come the power-good levels and then the general status inputs.

Top module: `stat_serial_reporter`

## Requirements
- R1: After reset the serial output is 0, the dirty flag (`fault_latched`) is 0, and a reset clears a dirty flag that was set.
- R2: A rising edge on `snap_req` copies the word {dirty, pg_in[3:0], stat_in[21:0]} (dirty at bit 26, power-good levels at bits 25..22, status at bits 21..0) into the shift register.
- R3: Bit 26 appears on `sdo` after the snapshot and before any shift clock edge. Each falling edge of `shift_clk` then presents the next lower bit, so a reader that samples while `shift_clk` is high receives the word MSB first.
- R4: After the 27th falling edge, further falling edges of `shift_clk` present 0 on `sdo` and do not start a new read.
- R5: A falling edge on any `pg_in` bit sets the dirty flag.
- R6: While the dirty flag is set, the recorded word keeps the status and power-good values it held when the failure was detected, whatever the inputs do afterwards, including later power-good falls.
- R7: A rising edge on a `pg_in` bit does not set the dirty flag.
- R8: A complete read (exactly 27 falling shift edges after a snapshot) that ends while `soft_off` is high clears the dirty flag. The record then follows the live inputs again.
- R9: A complete read while `soft_off` is low, or a read cut short, leaves the dirty flag set.
- R10: A new snapshot in the middle of a read restarts the transfer from bit 26 with a fresh copy of the record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local clock that oversamples every input |
| rst_n | input | 1 | Active-low reset (loss of AC power) |
| stat_in | input | 22 | Live general status bits, asynchronous |
| pg_in | input | 4 | Monitored power-good levels, asynchronous |
| soft_off | input | 1 | High while the system is in the soft-off state |
| snap_req | input | 1 | Snapshot request from the controller; its rising edge loads the shift register |
| shift_clk | input | 1 | Controller shift clock; its falling edge advances the output |
| sdo | output | 1 | Serial data, MSB first |
| fault_latched | output | 1 | Current value of the sticky dirty flag |

## Verification
Suppose the dirty flag is lost or fails to set. The first snapshot after the event then shows bit 26 clear, and the frozen status and power-good fields carry later values. This shows up one read after the failure, which is within a few hundred local cycles in the bench. A wrong bit counter moves every bit of the serial word by one position. It can also clear the flag at the wrong time or let a shortened read clear it, and `fault_latched` drops within a few cycles of the last shift edge. A frozen record that still follows the inputs shows up as a mismatch in the status field of the next read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    parameter int unsigned VEC_W_DEF       = 27;
    parameter int unsigned PG_W_DEF        = 4;
    parameter int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_phase_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ssr_recorder.sv
module ssr_recorder #(
    parameter int unsigned VEC_W = 27,
    parameter int unsigned PG_W  = 4,
    localparam int unsigned REC_W  = VEC_W - 1,
    localparam int unsigned STAT_W = VEC_W - 1 - PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PG_W-1:0]   pg_s,
    input  logic [STAT_W-1:0] stat_s,
    input  logic              clr_req,
    output logic [REC_W-1:0]  rec_vec,
    output logic              dirty,
    output logic              pg_fall
);
    typedef struct packed {
        logic [PG_W-1:0]  pg_prev;
        logic [REC_W-1:0] rec;
        logic             dirty;
    } rec_st_t;

    rec_st_t st_d, st_q;
    logic    fall_any;

    always_comb begin
        st_d         = st_q;
        st_d.pg_prev = pg_s;
        fall_any     = |(st_q.pg_prev & ~pg_s);
        if (!st_q.dirty) begin
            st_d.rec = {pg_s, stat_s};
        end
        if (fall_any) begin
            st_d.dirty = 1'b1;
        end else if (clr_req) begin
            st_d.dirty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_vec = st_q.rec;
    assign dirty   = st_q.dirty;
    assign pg_fall = fall_any;
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
#(
    parameter int unsigned VEC_W = 27,
    localparam int unsigned CNT_W = $clog2(VEC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             sclk_s,
    output logic             sdo,
    output logic             read_done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(VEC_W - 1);

    typedef struct packed {
        sh_phase_e        phase;
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [VEC_W-1:0] shreg;
        logic             done;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   sclk_fall;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.sclk_prev = sclk_s;
        sclk_fall      = st_q.sclk_prev & ~sclk_s;
        if (load) begin
            st_d.shreg = vec_in;
            st_d.cnt   = '0;
            st_d.phase = SH_BUSY;
        end else if (sclk_fall) begin
            st_d.shreg = {st_q.shreg[VEC_W-2:0], 1'b0};
            if (st_q.phase == SH_BUSY) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == LAST) begin
                    st_d.phase = SH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= SH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo       = st_q.shreg[VEC_W-1];
    assign read_done = st_q.done;
endmodule

// File: rtl/stat_serial_reporter.sv
module stat_serial_reporter
    import ssr_pkg::*;
#(
    parameter int unsigned VEC_W       = VEC_W_DEF,
    parameter int unsigned PG_W        = PG_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned STAT_W = VEC_W - 1 - PG_W,
    localparam int unsigned IN_W   = STAT_W + PG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [PG_W-1:0]   pg_in,
    input  logic              soft_off,
    input  logic              snap_req,
    input  logic              shift_clk,
    output logic              sdo,
    output logic              fault_latched
);
    logic [IN_W-1:0]   raw_in, syn_in;
    logic [STAT_W-1:0] stat_s;
    logic [PG_W-1:0]   pg_s;
    logic              off_s, snap_s, sclk_s;
    logic              snap_prev_d, snap_prev_q;
    logic              snap_load;
    logic [VEC_W-2:0]  rec_vec;
    logic              dirty, pg_fall, read_done, clr_req;

    assign raw_in = {stat_in, pg_in, soft_off, snap_req, shift_clk};

    ssr_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {stat_s, pg_s, off_s, snap_s, sclk_s} = syn_in;

    always_comb begin
        snap_prev_d = snap_s;
        snap_load   = snap_s & ~snap_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_prev_q <= 1'b0;
        else        snap_prev_q <= snap_prev_d;
    end

    assign clr_req = read_done & off_s;

    ssr_recorder #(.VEC_W(VEC_W), .PG_W(PG_W)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_s    (pg_s),
        .stat_s  (stat_s),
        .clr_req (clr_req),
        .rec_vec (rec_vec),
        .dirty   (dirty),
        .pg_fall (pg_fall)
    );

    ssr_shifter #(.VEC_W(VEC_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (snap_load),
        .vec_in    ({dirty, rec_vec}),
        .sclk_s    (sclk_s),
        .sdo       (sdo),
        .read_done (read_done)
    );

    assign fault_latched = dirty;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
    parameter int unsigned REC_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pg_fall,
    input logic             read_done,
    input logic             off_s,
    input logic             snap_load,
    input logic             fault_latched,
    input logic             sdo,
    input logic [REC_W-1:0] rec_vec
);
    AST_FALL_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        pg_fall |=> fault_latched); // R5

    AST_NO_SPURIOUS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_latched && !pg_fall) |=> !fault_latched); // R7

    AST_DIRTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && !(read_done && off_s)) |=> fault_latched); // R9

    AST_SOFTOFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && off_s && !pg_fall) |=> !fault_latched); // R8

    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_latched) |-> $stable(rec_vec)); // R6

    AST_LOAD_PRESENTS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        snap_load |=> (sdo == $past(fault_latched))); // R3
endmodule

bind stat_serial_reporter ssr_checker #(.REC_W(VEC_W - 1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pg_fall       (pg_fall),
    .read_done     (read_done),
    .off_s         (off_s),
    .snap_load     (snap_load),
    .fault_latched (fault_latched),
    .sdo           (sdo),
    .rec_vec       (rec_vec)
);

// File: tb/sim_stat_serial_reporter.sv
module sim_stat_serial_reporter;
    localparam int VEC_W  = 27;
    localparam int PG_W   = 4;
    localparam int STAT_W = VEC_W - 1 - PG_W;
    localparam int HOLD   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [STAT_W-1:0] stat_in = '0;
    logic [PG_W-1:0]   pg_in = '0;
    logic              soft_off = 1'b0;
    logic              snap_req = 1'b0;
    logic              shift_clk = 1'b0;
    logic              sdo, fault_latched;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stat_serial_reporter u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_in       (stat_in),
        .pg_in         (pg_in),
        .soft_off      (soft_off),
        .snap_req      (snap_req),
        .shift_clk     (shift_clk),
        .sdo           (sdo),
        .fault_latched (fault_latched)
    );

    function automatic logic [VEC_W-1:0] mk(input logic d, input logic [PG_W-1:0] pg,
                                            input logic [STAT_W-1:0] st);
        return {d, pg, st};
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk(output logic bit_hi);
        shift_clk = 1'b1;
        settle(HOLD);
        bit_hi = sdo;
        shift_clk = 1'b0;
        settle(HOLD);
    endtask

    task automatic snapshot();
        snap_req = 1'b1;
        settle(HOLD);
        snap_req = 1'b0;
        settle(HOLD);
    endtask

    task automatic do_read(input int nfalls, output logic [VEC_W-1:0] w);
        logic b;
        w = '0;
        snapshot();
        for (int i = 0; i < nfalls; i++) begin
            pulse_sclk(b);
            if (i < VEC_W) w[VEC_W-1-i] = b;
        end
    endtask

    task automatic t_reset();
        logic [VEC_W-1:0] w;
        check_eq("R1 sdo after reset", 32'(sdo), 32'h0);
        check_eq("R1 dirty after reset", 32'(fault_latched), 32'h0);
        check_eq("R7 pg rise at start leaves dirty clear", 32'(fault_latched), 32'h0);
        do_read(VEC_W, w);
        check_eq("R2 first read", 32'(w), 32'(mk(1'b0, pg_in, stat_in)));
    endtask

    task automatic t_patterns();
        logic [VEC_W-1:0] w;
        stat_in = 22'h2A5A5C;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R2 R3 pattern A", 32'(w), 32'(mk(1'b0, 4'hF, 22'h2A5A5C)));
        stat_in = 22'h15A5A3;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R2 R3 pattern B", 32'(w), 32'(mk(1'b0, 4'hF, 22'h15A5A3)));
        stat_in = 22'h000001;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R3 LSB lands last", 32'(w), 32'(mk(1'b0, 4'hF, 22'h000001)));
    endtask

    task automatic t_overrun();
        logic [VEC_W-1:0] w;
        logic b;
        stat_in = 22'h3FFFFF;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R4 full word before overrun", 32'(w), 32'(mk(1'b0, 4'hF, 22'h3FFFFF)));
        for (int i = 0; i < 3; i++) begin
            pulse_sclk(b);
            check_eq("R4 extra edge gives zero", 32'(b), 32'h0);
        end
    endtask

    task automatic t_restart();
        logic [VEC_W-1:0] w;
        stat_in = 22'h0F0F0F;
        settle(HOLD);
        do_read(5, w);
        stat_in = 22'h123456;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R10 restart gives full fresh word", 32'(w), 32'(mk(1'b0, 4'hF, 22'h123456)));
    endtask

    task automatic t_fail_and_freeze();
        logic [VEC_W-1:0] w;
        stat_in = 22'h2BCDEF;
        settle(HOLD);
        pg_in = 4'hB;
        settle(HOLD);
        check_eq("R5 pg fall sets dirty", 32'(fault_latched), 32'h1);
        stat_in = 22'h111111;
        pg_in   = 4'h3;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R6 frozen first failure", 32'(w), 32'(mk(1'b1, 4'hB, 22'h2BCDEF)));
        check_eq("R9 full read outside soft-off keeps dirty", 32'(fault_latched), 32'h1);
    endtask

    task automatic t_clear();
        logic [VEC_W-1:0] w;
        soft_off = 1'b1;
        settle(HOLD);
        do_read(20, w);
        check_eq("R9 short read in soft-off keeps dirty", 32'(fault_latched), 32'h1);
        do_read(VEC_W, w);
        check_eq("R8 clearing read still shows frozen word", 32'(w), 32'(mk(1'b1, 4'hB, 22'h2BCDEF)));
        check_eq("R8 dirty cleared", 32'(fault_latched), 32'h0);
        soft_off = 1'b0;
        settle(HOLD);
        do_read(VEC_W, w);
        check_eq("R8 record follows live inputs again", 32'(w), 32'(mk(1'b0, 4'h3, 22'h111111)));
    endtask

    task automatic t_pg_rise();
        pg_in = 4'hF;
        settle(HOLD);
        check_eq("R7 pg rise leaves dirty clear", 32'(fault_latched), 32'h0);
    endtask

    task automatic t_reset_clears();
        logic [VEC_W-1:0] w;
        pg_in = 4'h1;
        settle(HOLD);
        check_eq("R5 second failure sets dirty", 32'(fault_latched), 32'h1);
        rst_n = 1'b0;
        settle(4);
        rst_n = 1'b1;
        settle(HOLD);
        check_eq("R1 reset clears dirty", 32'(fault_latched), 32'h0);
        do_read(VEC_W, w);
        check_eq("R1 record live after reset", 32'(w), 32'(mk(1'b0, 4'h1, 22'h111111)));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        pg_in = 4'hF;
        stat_in = 22'h0A0A0A;
        settle(5);
        rst_n = 1'b1;
        settle(HOLD);
        t_reset();
        t_patterns();
        t_overrun();
        t_restart();
        t_fail_and_freeze();
        t_clear();
        t_pg_rise();
        t_reset_clears();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule